// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block performs one data-processing operation per cycle on a first operand and an already-shifted second operand. A 4-bit operation code selects one of sixteen functions: six adder forms (plain, carry-in, subtract, subtract with borrow, and the two reversed-operand subtracts), six bitwise forms (AND, OR, XOR, bit clear, pass, pass-inverted) and four flag-only forms (compare, compare-negated, test, test-equal). The 32-bit result and its write-enable are combinational from the inputs in the cycle that `op_valid` is high.

The negative, zero, carry and overflow flags are held in a register inside the block. They are loaded at the clock edge that ends a valid operation, but only if the set-flags input is high or the operation is one of the flag-only forms. The carry-in of the carry-using forms comes from the stored carry flag, so a flag-setting add followed by an add with carry builds a sum wider than 32 bits.

Top module: `dp_alu_core`

## Requirements
- R1: Codes 4 ADD, 2 SUB and 3 RSB give a+b, a−b and b−a, each modulo 2^32.
- R2: Codes 5 ADC, 6 SBC and 7 RSC give a+b+C, a−b−(1−C) and b−a−(1−C), with C the stored carry flag.
- R3: For every subtracting form (SUB, SBC, RSB, RSC, CMP) the new C is 1 when no borrow occurred and 0 when one did; for adding forms C is the carry out of bit 31.
- R4: Codes 0 AND, 1 XOR, 12 OR, 13 MOV (b), 14 BIC (a AND NOT b) and 15 MVN (NOT b) give the bitwise result.
- R5: Codes 8 TST (a AND b), 9 TEQ (a XOR b), 10 CMP (a−b) and 11 CMN (a+b) keep `result_we` low and update the flags even when `set_flags` is 0.
- R6: A flag update from a bitwise or test form loads C from `shift_carry` and leaves V at its previous value.
- R7: A flag update from an adder or compare form sets V to the signed two's-complement overflow of the operation.
- R8: On any flag update N is bit 31 of the operation value and Z is 1 exactly when that value is zero (a flag-setting MOV of 0 gives Z=1, N=0).
- R9: When `set_flags` is 0 and the code is not a flag-only form, or when `op_valid` is 0, all four flags keep their values; `result_we` is 0 whenever `op_valid` is 0.
- R10: While `rst_n` is low the flags are 0000; reset is asynchronous.
- R11: A flag-setting ADD on the low halves followed by ADC on the high halves gives the correct 64-bit sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| opcode | input | 4 | Operation code (see R1–R5) |
| set_flags | input | 1 | Request flag update for non-flag-only forms |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand, after the shifter |
| shift_carry | input | 1 | Carry out of the shifter |
| result | output | 32 | Operation value |
| result_we | output | 1 | Destination write-enable |
| flags_nzcv | output | 4 | Stored flags: bit 3 N, bit 2 Z, bit 1 C, bit 0 V |

## Verification
Assertions watch on every cycle that flag-only forms never raise the write-enable, that flags stay frozen when no update is due, that bitwise updates keep V, and that N and Z after an update match the value shown the cycle before. The exact arithmetic values, the borrow sense of C, signed overflow, the carry chain into ADC, SBC and RSC, and the 64-bit add across two operations can only be shown by the bench's scenarios, which compare against an independent model of the flags.

// File: rtl/dpalu_pkg.sv
package dpalu_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_XOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  function automatic logic op_is_adder(alu_op_e op);
    return (op inside {OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC, OP_CMP, OP_CMN});
  endfunction

  function automatic logic op_is_flag_only(alu_op_e op);
    return (op inside {OP_TST, OP_TEQ, OP_CMP, OP_CMN});
  endfunction
endpackage

// File: rtl/alu_adder.sv
module alu_adder
  import dpalu_pkg::*;
#(
  parameter int DW = 32
) (
  input  alu_op_e         op,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  input  logic            c_in,
  output logic [DW-1:0]   sum,
  output logic            c_out,
  output logic            ovf
);
  localparam int MSB = DW - 1;

  logic [DW-1:0] x;
  logic [DW-1:0] y;
  logic          ci;
  logic [DW:0]   wide;

  // Subtraction is x + ~y + carry, so carry-out means "no borrow".
  always_comb begin
    x  = a;
    y  = b;
    ci = 1'b0;
    unique case (op)
      OP_ADD, OP_CMN: begin x = a; y = b;  ci = 1'b0; end
      OP_ADC:         begin x = a; y = b;  ci = c_in; end
      OP_SUB, OP_CMP: begin x = a; y = ~b; ci = 1'b1; end
      OP_SBC:         begin x = a; y = ~b; ci = c_in; end
      OP_RSB:         begin x = b; y = ~a; ci = 1'b1; end
      OP_RSC:         begin x = b; y = ~a; ci = c_in; end
      default:        begin x = a; y = b;  ci = 1'b0; end
    endcase
  end

  assign wide  = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, ci};
  assign sum   = wide[MSB:0];
  assign c_out = wide[DW];
  assign ovf   = (x[MSB] == y[MSB]) && (wide[MSB] != x[MSB]);
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
  import dpalu_pkg::*;
#(
  parameter int DW = 32
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);
  always_comb begin
    unique case (op)
      OP_AND, OP_TST: y = a & b;
      OP_XOR, OP_TEQ: y = a ^ b;
      OP_ORR:         y = a | b;
      OP_MOV:         y = b;
      OP_BIC:         y = a & ~b;
      OP_MVN:         y = ~b;
      default:        y = '0;
    endcase
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import dpalu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_en,
  input  nzcv_t d,
  output nzcv_t q
);
  nzcv_t q_nxt;

  always_comb begin
    q_nxt = q;
    if (load_en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/dp_alu_core.sv
module dp_alu_core
  import dpalu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [3:0]    opcode,
  input  logic          set_flags,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic          shift_carry,
  output logic [DW-1:0] result,
  output logic          result_we,
  output logic [3:0]    flags_nzcv
);
  localparam int MSB = DW - 1;

  alu_op_e       op;
  nzcv_t         flg_q;
  nzcv_t         flg_d;
  logic          use_adder;
  logic          flag_only;
  logic          flag_load;
  logic [DW-1:0] add_sum;
  logic          add_cout;
  logic          add_ovf;
  logic [DW-1:0] bit_res;

  assign op        = alu_op_e'(opcode);
  assign use_adder = op_is_adder(op);
  assign flag_only = op_is_flag_only(op);

  alu_adder #(.DW(DW)) adder_i (
    .op(op), .a(opa), .b(opb), .c_in(flg_q.c),
    .sum(add_sum), .c_out(add_cout), .ovf(add_ovf)
  );

  alu_bitwise #(.DW(DW)) bitwise_i (
    .op(op), .a(opa), .b(opb), .y(bit_res)
  );

  assign result    = use_adder ? add_sum : bit_res;
  assign result_we = op_valid && !flag_only;
  assign flag_load = op_valid && (set_flags || flag_only);

  always_comb begin
    flg_d.n = result[MSB];
    flg_d.z = ~|result;
    flg_d.c = use_adder ? add_cout : shift_carry;
    flg_d.v = use_adder ? add_ovf  : flg_q.v;
  end

  alu_flag_reg flag_reg_i (
    .clk(clk), .rst_n(rst_n), .load_en(flag_load), .d(flg_d), .q(flg_q)
  );

  assign flags_nzcv = flg_q;

  // R5
  flag_only_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode[3:2] == 2'b10) |-> !result_we);

  // R9
  idle_flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid || (!set_flags && opcode[3:2] != 2'b10)) |=> $stable(flags_nzcv));

  // R6
  bitwise_keeps_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && set_flags && opcode inside {4'd0, 4'd1, 4'd12, 4'd13, 4'd14, 4'd15})
    |=> (flags_nzcv[0] == $past(flags_nzcv[0]) && flags_nzcv[1] == $past(shift_carry)));

  // R8
  nz_track_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && set_flags)
    |=> (flags_nzcv[3] == $past(result[MSB]) && flags_nzcv[2] == ($past(result) == '0)));

  // R9
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> !result_we);
endmodule

// File: tb/dp_alu_core_tb_top.sv
`timescale 1ns/1ps
module dp_alu_core_tb_top;
  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [3:0]  opcode;
  logic        set_flags;
  logic [31:0] opa;
  logic [31:0] opb;
  logic        shift_carry;
  logic [31:0] result;
  logic        result_we;
  logic [3:0]  flags_nzcv;

  int checks = 0;
  int errors = 0;
  logic [3:0] exp_f;

  typedef struct packed {
    logic [3:0]  op;
    logic        s;
    logic [31:0] a;
    logic [31:0] b;
    logic        sc;
    logic [31:0] res;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{4'd4,  1'b1, 32'd3,          32'd5,          1'b0, 32'd8},          // R1 ADD
    '{4'd2,  1'b1, 32'd3,          32'd5,          1'b0, 32'hFFFFFFFE},   // R1 R3 borrow
    '{4'd2,  1'b1, 32'd5,          32'd3,          1'b0, 32'd2},          // R3 no borrow
    '{4'd3,  1'b1, 32'd3,          32'd5,          1'b0, 32'd2},          // R1 RSB
    '{4'd0,  1'b1, 32'hF0F0F0F0,   32'hFF00FF00,   1'b1, 32'hF000F000},   // R4 AND
    '{4'd1,  1'b1, 32'hF0F0F0F0,   32'hFF00FF00,   1'b0, 32'h0FF00FF0},   // R4 XOR
    '{4'd12, 1'b1, 32'hF0F0F0F0,   32'hFF00FF00,   1'b1, 32'hFFF0FFF0},   // R4 OR
    '{4'd14, 1'b1, 32'h11111111,   32'h01100101,   1'b0, 32'h10011010},   // R4 BIC
    '{4'd13, 1'b1, 32'h12345678,   32'd0,          1'b0, 32'd0},          // R8 MOV zero
    '{4'd15, 1'b1, 32'd0,          32'd0,          1'b1, 32'hFFFFFFFF},   // R4 MVN
    '{4'd4,  1'b1, 32'h7FFFFFFF,   32'd1,          1'b0, 32'h80000000},   // R7 overflow
    '{4'd4,  1'b0, 32'hFFFFFFFF,   32'd1,          1'b0, 32'd0},          // R9 no S
    '{4'd5,  1'b1, 32'd1,          32'd1,          1'b0, 32'd2},          // R2 ADC C=0
    '{4'd6,  1'b1, 32'd5,          32'd3,          1'b0, 32'd1},          // R2 SBC C=0
    '{4'd7,  1'b1, 32'd3,          32'd5,          1'b0, 32'd2},          // R2 RSC C=1
    '{4'd10, 1'b0, 32'd5,          32'd5,          1'b0, 32'd0},          // R5 CMP
    '{4'd8,  1'b0, 32'd1,          32'd2,          1'b1, 32'd0}           // R5 TST
  };

  dp_alu_core dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .set_flags(set_flags), .opa(opa), .opb(opb), .shift_carry(shift_carry),
    .result(result), .result_we(result_we), .flags_nzcv(flags_nzcv)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Independent flag model: plain signed/unsigned arithmetic in 64 bits.
  function automatic logic [3:0] model(input logic [3:0] op, input logic s,
      input logic [31:0] a, input logic [31:0] b, input logic sc, input logic [3:0] old);
    longint u, sv, xs, ys, xu, yu;
    logic [31:0] r;
    logic n, z, c, v, cin, fo, ar, sub;
    cin = old[1];
    fo  = (op[3:2] == 2'b10);
    ar  = (op inside {4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd10, 4'd11});
    if (!(s || fo)) return old;
    c = sc;
    v = old[0];
    if (ar) begin
      sub = (op inside {4'd2, 4'd3, 4'd6, 4'd7, 4'd10});
      xu = (op == 4'd3 || op == 4'd7) ? longint'(b) : longint'(a);
      yu = (op == 4'd3 || op == 4'd7) ? longint'(a) : longint'(b);
      xs = (op == 4'd3 || op == 4'd7) ? longint'($signed(b)) : longint'($signed(a));
      ys = (op == 4'd3 || op == 4'd7) ? longint'($signed(a)) : longint'($signed(b));
      if (sub) begin
        logic [0:0] bin;
        bin = (op == 4'd6 || op == 4'd7) ? !cin : 1'b0;
        u  = xu - yu - longint'(bin);
        sv = xs - ys - longint'(bin);
        c  = (u >= 0);
      end else begin
        logic [0:0] ci;
        ci = (op == 4'd5) ? cin : 1'b0;
        u  = xu + yu + longint'(ci);
        sv = xs + ys + longint'(ci);
        c  = (u > longint'(32'hFFFFFFFF));
      end
      r = u[31:0];
      v = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
    end else begin
      case (op)
        4'd0, 4'd8:  r = a & b;
        4'd1, 4'd9:  r = a ^ b;
        4'd12:       r = a | b;
        4'd13:       r = b;
        4'd14:       r = a & ~b;
        default:     r = ~b;
      endcase
    end
    n = r[31];
    z = (r == 32'd0);
    return {n, z, c, v};
  endfunction

  // Drive at falling edge, check combinational outputs, then flags after the edge.
  task automatic run_op(input string tag, input logic [3:0] op, input logic s,
      input logic [31:0] a, input logic [31:0] b, input logic sc,
      input logic chk_res, input logic [31:0] exp_res);
    @(negedge clk);
    op_valid = 1'b1; opcode = op; set_flags = s; opa = a; opb = b; shift_carry = sc;
    #1;
    if (chk_res) chk({tag, " result"}, result, exp_res);
    chk({tag, " we"}, {31'd0, result_we}, {31'd0, op[3:2] != 2'b10});
    exp_f = model(op, s, a, b, sc, exp_f);
    @(posedge clk);
    #1;
    op_valid = 1'b0;
    chk({tag, " flags"}, {28'd0, flags_nzcv}, {28'd0, exp_f});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; opcode = '0; set_flags = 1'b0;
    opa = '0; opb = '0; shift_carry = 1'b0;
    exp_f = 4'b0000;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset flags", {28'd0, flags_nzcv}, 32'd0);
    chk("R9 idle we", {31'd0, result_we}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run_op($sformatf("vec%0d", i), VEC[i].op, VEC[i].s, VEC[i].a, VEC[i].b,
             VEC[i].sc, VEC[i].op[3:2] != 2'b10, VEC[i].res);
    end

    // R11: 64-bit add 0x00000001_FFFFFFFF + 0x00000002_00000001 = 0x00000004_00000000
    run_op("R11 low", 4'd4, 1'b1, 32'hFFFFFFFF, 32'h00000001, 1'b0, 1'b1, 32'h0);
    run_op("R11 high", 4'd5, 1'b1, 32'h00000001, 32'h00000002, 1'b0, 1'b1, 32'h4);

    // R6: set V by overflow, then a flag-setting MOV of 0 keeps V, takes C from shifter
    run_op("R7 ovf sub", 4'd2, 1'b1, 32'h80000000, 32'd1, 1'b0, 1'b1, 32'h7FFFFFFF);
    run_op("R6 movs zero", 4'd13, 1'b1, 32'hDEADBEEF, 32'd0, 1'b1, 1'b1, 32'd0);
    chk("R6 V kept", {31'd0, flags_nzcv[0]}, 32'd1);
    chk("R8 Z set N clear", {30'd0, flags_nzcv[3:2]}, 32'd1);

    // R5: TEQ and CMN update flags with S=0
    run_op("R5 teq", 4'd9, 1'b0, 32'hA5A5A5A5, 32'hA5A5A5A5, 1'b0, 1'b0, 32'd0);
    run_op("R5 cmn", 4'd11, 1'b0, 32'hFFFFFFFF, 32'd1, 1'b0, 1'b0, 32'd0);

    // R9: op_valid low with a compare code leaves flags untouched
    @(negedge clk);
    opcode = 4'd10; set_flags = 1'b1; opa = 32'd1; opb = 32'd2; op_valid = 1'b0;
    #1;
    chk("R9 invalid we", {31'd0, result_we}, 32'd0);
    @(posedge clk);
    #1;
    chk("R9 invalid flags", {28'd0, flags_nzcv}, {28'd0, exp_f});

    // R10: asynchronous reset clears flags
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R10 async clear", {28'd0, flags_nzcv}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    exp_f = 4'b0000;
    run_op("R2 adc after reset", 4'd5, 1'b0, 32'd10, 32'd20, 1'b0, 1'b1, 32'd30);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule